// File: doc/BRIEF.md
# MII Management PHY Register Model

This block is a behavioural model of the register file inside a single Ethernet PHY. A MAC drives it through the contents of its management registers. An address word carries the PHY address and the register index. A control word carries 16 bits of write data. Separate write and read strobes start each access. The result of a read is latched into a 16-bit management status output, where the MAC picks it up as the read result.

The model holds 32 registers of 16 bits, each with a fixed power-on value. A link-up input forces the link and auto-negotiation-complete bits of the basic status register, but only when the link state changes. A write to the basic control register completes auto-negotiation at once. A write that carries the control register's reset bit reloads every register. Accesses addressed to a PHY address other than the configured one are ignored, and a read addressed that way returns all ones.

Top module: `miim_phy_model`

## Requirements
- R1: After reset, register 0 holds 0x1140, register 1 holds 0x7968, register 2 holds 0x0022, register 3 holds 0x1550, register 4 holds 0x01E1, register 5 holds 0xCDE1, every other register holds 0, and `mgmt_status` is 0.
- R2: The register index is bits 4:0 of `mgmt_addr_word` and the PHY address is bits 12:8. All other address-word bits are ignored. Write data is bits 15:0 of `mgmt_ctl_word`, and bits 31:16 are ignored.
- R3: A read strobe with a matching PHY address loads the addressed register into `mgmt_status` at the next clock edge, using its value from before any write made on that same edge. Without a read strobe, `mgmt_status` holds its value.
- R4: A write strobe with a matching PHY address stores the write data into the addressed register. This applies to every register except a control-register write with bit 15 set.
- R5: The model assumes the link is down at reset. When `link_up` rises, status bits 5 (auto-negotiation complete) and 2 (link up) are set at the next edge. When it falls, both bits are cleared. On those two bits, a link change takes priority over a write made on the same edge.
- R6: A matching write to register 0 with bit 15 clear stores the data and sets status bit 5.
- R7: A matching write to register 0 with bit 15 set restores every register to its R1 value, so register 0 then reads 0x1140. Link tracking restarts from down, so a link that is up sets status bits 5 and 2 again one edge later.
- R8: A write whose PHY address does not match `phy_addr_cfg` changes no register.
- R9: A read whose PHY address does not match `phy_addr_cfg` returns 0xFFFF in `mgmt_status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phy_addr_cfg | input | 5 | PHY address this model answers to |
| mgmt_addr_word | input | 16 | Management address word (register index and PHY address) |
| mgmt_ctl_word | input | 32 | Management control word (write data in low half) |
| wr_stb | input | 1 | Single-cycle write request |
| rd_stb | input | 1 | Single-cycle read request |
| link_up | input | 1 | Current link state |
| mgmt_status | output | 16 | Read result register |

## Verification
The assertions take for granted that `phy_addr_cfg` is static once reset is released. They also assume each strobe is a one-cycle pulse whose address and control words are valid in that cycle. The bench changes `phy_addr_cfg` only while reset is asserted. It drives every strobe and its words together on a falling edge and drops the strobe on the following falling edge. It leaves `link_up` unchanged across the idle cycle in which the model records a link event. The one exception is the deliberate same-edge collision of a link change with a status write.

// File: rtl/miim_phy_pkg.sv
package miim_phy_pkg;
  localparam int DATA_W      = 16;
  localparam int CTRL_IDX    = 0;
  localparam int STAT_IDX    = 1;
  localparam int AN_DONE_BIT = 5;
  localparam int LINK_BIT    = 2;
  localparam int SRESET_BIT  = 15;

  // power-on contents of each register index
  function automatic logic [DATA_W-1:0] phy_reset_value(input int idx);
    case (idx)
      0:       return 16'h1140;
      1:       return 16'h7968;
      2:       return 16'h0022;
      3:       return 16'h1550;
      4:       return 16'h01E1;
      5:       return 16'hCDE1;
      default: return '0;
    endcase
  endfunction

  // force the two link-derived status bits to the given level
  function automatic logic [DATA_W-1:0] status_force(input logic [DATA_W-1:0] v,
                                                     input logic up);
    logic [DATA_W-1:0] r;
    r = v;
    r[AN_DONE_BIT] = up;
    r[LINK_BIT]    = up;
    return r;
  endfunction

  // pull an unsigned field out of a word
  function automatic logic [31:0] field_get(input logic [31:0] word, input int lsb,
                                            input int width);
    return (word >> lsb) & ((32'd1 << width) - 32'd1);
  endfunction
endpackage

// File: rtl/miim_mgmt_decode.sv
module miim_mgmt_decode
  import miim_phy_pkg::*;
#(
  parameter int REG_ADDR_W    = 5,
  parameter int PHY_ADDR_W    = 5,
  parameter int PHY_FIELD_LSB = 8,
  parameter int ADDR_WORD_W   = 16,
  parameter int CTL_WORD_W    = 32
) (
  input  logic [ADDR_WORD_W-1:0] addr_word,
  input  logic [CTL_WORD_W-1:0]  ctl_word,
  input  logic [PHY_ADDR_W-1:0]  phy_addr_cfg,
  input  logic                   wr_stb,
  input  logic                   rd_stb,
  output logic [REG_ADDR_W-1:0]  reg_idx,
  output logic [DATA_W-1:0]      wr_data,
  output logic                   phy_hit,
  output logic                   rd_hit,
  output logic                   reg_wr,
  output logic                   soft_reset,
  output logic                   an_set
);
  logic [PHY_ADDR_W-1:0] phy_sel;
  logic                  wr_hit;
  logic                  ctrl_sel;
  logic                  unused_word_bits;

  assign reg_idx  = REG_ADDR_W'(field_get(32'(addr_word), 0, REG_ADDR_W));
  assign phy_sel  = PHY_ADDR_W'(field_get(32'(addr_word), PHY_FIELD_LSB, PHY_ADDR_W));
  assign wr_data  = ctl_word[DATA_W-1:0];
  assign unused_word_bits = ^{addr_word, ctl_word};

  assign phy_hit  = (phy_sel == phy_addr_cfg);
  assign rd_hit   = rd_stb && phy_hit;
  assign wr_hit   = wr_stb && phy_hit;
  assign ctrl_sel = (reg_idx == REG_ADDR_W'(CTRL_IDX));

  assign soft_reset = wr_hit && ctrl_sel && wr_data[SRESET_BIT];
  assign reg_wr     = wr_hit && !soft_reset;
  assign an_set     = reg_wr && ctrl_sel;
endmodule

// File: rtl/miim_link_tracker.sv
module miim_link_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic link_up,
  input  logic soft_reset,
  output logic link_evt,
  output logic link_level
);
  logic link_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          link_q <= 1'b0;
    else if (soft_reset) link_q <= 1'b0;
    else                 link_q <= link_up;
  end

  assign link_evt   = (link_up != link_q);
  assign link_level = link_up;

  // R7: after a soft reset the tracker treats the link as down again
  a_r7_link_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_reset && link_up) |=> link_evt || !link_up);
endmodule

// File: rtl/miim_phy_regfile.sv
module miim_phy_regfile
  import miim_phy_pkg::*;
#(
  parameter int REG_ADDR_W = 5,
  localparam int NUM_REGS  = 1 << REG_ADDR_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic [REG_ADDR_W-1:0]      wr_idx,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       soft_reset,
  input  logic                       an_set,
  input  logic                       link_evt,
  input  logic                       link_level,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] cur;
    logic [DATA_W-1:0] nxt;

    always_comb begin
      nxt = cur;
      if (reg_wr && (wr_idx == REG_ADDR_W'(i))) nxt = wr_data;
      if (i == STAT_IDX) begin
        if (an_set)   nxt[AN_DONE_BIT] = 1'b1;
        if (link_evt) nxt = status_force(nxt, link_level);
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)          cur <= phy_reset_value(i);
      else if (soft_reset) cur <= phy_reset_value(i);
      else                 cur <= nxt;
    end

    assign regs_flat[i*DATA_W +: DATA_W] = cur;
  end

  logic [DATA_W-1:0] stat_now;
  logic [DATA_W-1:0] ctrl_now;
  assign stat_now = regs_flat[STAT_IDX*DATA_W +: DATA_W];
  assign ctrl_now = regs_flat[CTRL_IDX*DATA_W +: DATA_W];

  // R5: link rise sets both status bits, link fall clears them
  a_r5_link_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (link_evt && link_level && !soft_reset) |=> (stat_now[AN_DONE_BIT] && stat_now[LINK_BIT]));
  a_r5_link_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (link_evt && !link_level && !soft_reset) |=> (!stat_now[AN_DONE_BIT] && !stat_now[LINK_BIT]));
  // R6: control write completes auto-negotiation
  a_r6_an_complete: assert property (@(posedge clk) disable iff (!rst_n)
    (an_set && !(link_evt && !link_level)) |=> stat_now[AN_DONE_BIT]);
  // R7: soft reset reloads the control register
  a_r7_ctrl_reload: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |=> (ctrl_now == phy_reset_value(CTRL_IDX)));
endmodule

// File: rtl/miim_read_port.sv
module miim_read_port
  import miim_phy_pkg::*;
#(
  parameter int REG_ADDR_W = 5,
  localparam int NUM_REGS  = 1 << REG_ADDR_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_stb,
  input  logic                       rd_hit,
  input  logic [REG_ADDR_W-1:0]      rd_idx,
  input  logic [NUM_REGS*DATA_W-1:0] regs_flat,
  output logic [DATA_W-1:0]          mgmt_status
);
  logic [DATA_W-1:0] sel_val;

  assign sel_val = regs_flat[int'(rd_idx)*DATA_W +: DATA_W];

  always_ff @(posedge clk) begin
    if (!rst_n)      mgmt_status <= '0;
    else if (rd_stb) mgmt_status <= rd_hit ? sel_val : {DATA_W{1'b1}};
  end

  // R9: unmatched read returns all ones
  a_r9_miss_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !rd_hit) |=> (mgmt_status == {DATA_W{1'b1}}));
  // R3: result register holds between reads
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(mgmt_status));
  // R3: matched read returns the pre-edge register value
  a_r3_read_value: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> (mgmt_status == $past(sel_val)));
endmodule

// File: rtl/miim_phy_model.sv
module miim_phy_model
  import miim_phy_pkg::*;
#(
  parameter int REG_ADDR_W    = 5,
  parameter int PHY_ADDR_W    = 5,
  parameter int PHY_FIELD_LSB = 8,
  parameter int ADDR_WORD_W   = 16,
  parameter int CTL_WORD_W    = 32,
  localparam int NUM_REGS     = 1 << REG_ADDR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PHY_ADDR_W-1:0]  phy_addr_cfg,
  input  logic [ADDR_WORD_W-1:0] mgmt_addr_word,
  input  logic [CTL_WORD_W-1:0]  mgmt_ctl_word,
  input  logic                   wr_stb,
  input  logic                   rd_stb,
  input  logic                   link_up,
  output logic [DATA_W-1:0]      mgmt_status
);
  logic [REG_ADDR_W-1:0]      reg_idx;
  logic [DATA_W-1:0]          wr_data;
  logic                       phy_hit;
  logic                       rd_hit;
  logic                       reg_wr;
  logic                       soft_reset;
  logic                       an_set;
  logic                       link_evt;
  logic                       link_level;
  logic [NUM_REGS*DATA_W-1:0] regs_flat;

  miim_mgmt_decode #(
    .REG_ADDR_W(REG_ADDR_W), .PHY_ADDR_W(PHY_ADDR_W), .PHY_FIELD_LSB(PHY_FIELD_LSB),
    .ADDR_WORD_W(ADDR_WORD_W), .CTL_WORD_W(CTL_WORD_W)
  ) u_decode (
    .addr_word(mgmt_addr_word), .ctl_word(mgmt_ctl_word), .phy_addr_cfg(phy_addr_cfg),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .reg_idx(reg_idx), .wr_data(wr_data),
    .phy_hit(phy_hit), .rd_hit(rd_hit), .reg_wr(reg_wr), .soft_reset(soft_reset),
    .an_set(an_set)
  );

  miim_link_tracker u_link (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .soft_reset(soft_reset),
    .link_evt(link_evt), .link_level(link_level)
  );

  miim_phy_regfile #(.REG_ADDR_W(REG_ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .wr_idx(reg_idx), .wr_data(wr_data),
    .soft_reset(soft_reset), .an_set(an_set), .link_evt(link_evt),
    .link_level(link_level), .regs_flat(regs_flat)
  );

  miim_read_port #(.REG_ADDR_W(REG_ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_hit(rd_hit), .rd_idx(reg_idx),
    .regs_flat(regs_flat), .mgmt_status(mgmt_status)
  );

  // R8: a write to another PHY address leaves every register untouched
  a_r8_miss_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !phy_hit && !link_evt) |=> $stable(regs_flat));
  // R4: a plain matched write lands in the addressed register
  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_idx != REG_ADDR_W'(STAT_IDX))) |=>
      (regs_flat[int'($past(reg_idx))*DATA_W +: DATA_W] == $past(wr_data)));
endmodule

// File: tb/sim_miim_phy_model.sv
`timescale 1ns/1ps
module sim_miim_phy_model;
  localparam logic [4:0] MY_PHY = 5'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  phy_addr_cfg = MY_PHY;
  logic [15:0] mgmt_addr_word = '0;
  logic [31:0] mgmt_ctl_word = '0;
  logic        wr_stb = 1'b0;
  logic        rd_stb = 1'b0;
  logic        link_up = 1'b0;
  logic [15:0] mgmt_status;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] exp_regs [32];
  logic [15:0] got;

  always #2 clk = ~clk;

  miim_phy_model u0 (
    .clk(clk), .rst_n(rst_n), .phy_addr_cfg(phy_addr_cfg), .mgmt_addr_word(mgmt_addr_word),
    .mgmt_ctl_word(mgmt_ctl_word), .wr_stb(wr_stb), .rd_stb(rd_stb), .link_up(link_up),
    .mgmt_status(mgmt_status)
  );

  function automatic logic [15:0] spec_value(input int r);
    logic [15:0] t [6] = '{16'h1140, 16'h7968, 16'h0022, 16'h1550, 16'h01E1, 16'hCDE1};
    return (r < 6) ? t[r] : 16'h0000;
  endfunction

  // address word with noise in the ignored fields (R2)
  function automatic logic [15:0] aword(input logic [4:0] phy, input logic [4:0] r);
    return {3'b101, phy, 3'b110, r};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 32; i++) exp_regs[i] = spec_value(i);
  endtask

  task automatic model_link(input logic up);
    exp_regs[1][5] = up;
    exp_regs[1][2] = up;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [4:0] phy, input logic [4:0] r, input logic [15:0] d);
    @(negedge clk);
    mgmt_addr_word = aword(phy, r);
    mgmt_ctl_word  = {16'hA5C3, d};
    wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    if (phy == MY_PHY) begin
      if (r == 5'd0 && d[15]) model_reset();
      else begin
        exp_regs[r] = d;
        if (r == 5'd0) exp_regs[1][5] = 1'b1;
      end
    end
  endtask

  task automatic do_read(input logic [4:0] phy, input logic [4:0] r, output logic [15:0] v);
    @(negedge clk);
    mgmt_addr_word = aword(phy, r);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    v = mgmt_status;
  endtask

  task automatic set_link(input logic up);
    @(negedge clk);
    link_up = up;
    @(negedge clk);
    model_link(up);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 status after reset", mgmt_status, 16'h0000);

    // R1 / R3: every register reads back its power-on value
    for (int r = 0; r < 32; r++) begin
      do_read(MY_PHY, 5'(r), got);
      check("R1 reset value", got, spec_value(r));
    end

    // R9: reads to every other PHY address return all ones
    for (int p = 0; p < 32; p++) begin
      if (5'(p) != MY_PHY) begin
        do_read(5'(p), 5'd2, got);
        check("R9 miss read", got, 16'hFFFF);
      end
    end

    // R3: status holds while no read strobe
    repeat (3) @(negedge clk);
    check("R3 hold", mgmt_status, 16'hFFFF);

    // R5: link rise and fall
    set_link(1'b1);
    do_read(MY_PHY, 5'd1, got);
    check("R5 link up status", got, 16'h796C);
    set_link(1'b0);
    do_read(MY_PHY, 5'd1, got);
    check("R5 link down status", got, 16'h7948);

    // R6: control write completes auto-negotiation
    do_write(MY_PHY, 5'd0, 16'h0100);
    do_read(MY_PHY, 5'd1, got);
    check("R6 an complete bit", got, 16'h7968);
    do_read(MY_PHY, 5'd0, got);
    check("R6 control stored", got, 16'h0100);

    // R4 / R2: write sweep over registers 1..31, then readback
    for (int r = 1; r < 32; r++)
      do_write(MY_PHY, 5'(r), 16'((r * 16'h0911) ^ 16'h5A3C));
    for (int r = 0; r < 32; r++) begin
      do_read(MY_PHY, 5'(r), got);
      check("R4 R2 write readback", got, exp_regs[r]);
    end

    // R8: writes to other PHY addresses change nothing
    for (int p = 0; p < 32; p++)
      if (5'(p) != MY_PHY) do_write(5'(p), 5'd4, 16'hDEAD);
    do_read(MY_PHY, 5'd4, got);
    check("R8 miss write ignored", got, exp_regs[4]);
    do_read(MY_PHY, 5'd0, got);
    check("R8 miss write ignored ctrl", got, exp_regs[0]);

    // R3: read and write on the same edge returns the old value
    @(negedge clk);
    mgmt_addr_word = aword(MY_PHY, 5'd6);
    mgmt_ctl_word  = 32'h0000_BEEF;
    wr_stb = 1'b1;
    rd_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    rd_stb = 1'b0;
    check("R3 read before write", mgmt_status, exp_regs[6]);
    exp_regs[6] = 16'hBEEF;
    do_read(MY_PHY, 5'd6, got);
    check("R3 read after write", got, 16'hBEEF);

    // R7: soft reset with link up
    set_link(1'b1);
    do_write(MY_PHY, 5'd0, 16'h8000);
    @(negedge clk);
    model_link(1'b1);
    for (int r = 0; r < 32; r++) begin
      do_read(MY_PHY, 5'(r), got);
      check("R7 soft reset value", got, exp_regs[r]);
    end
    check("R7 status relinked", exp_regs[1], 16'h796C);

    // R5: link change beats a status write on the same edge
    @(negedge clk);
    mgmt_addr_word = aword(MY_PHY, 5'd1);
    mgmt_ctl_word  = 32'h0000_FFFF;
    wr_stb  = 1'b1;
    link_up = 1'b0;
    @(negedge clk);
    wr_stb = 1'b0;
    do_read(MY_PHY, 5'd1, got);
    check("R5 link wins over write", got, 16'hFFDB);

    finish_run();
  end
endmodule